// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A 32-pin general-purpose I/O port that sits behind a single-cycle register bus. Every pin owns one output latch bit and one drive-enable bit. Neither bit can be written directly. Software changes them only through separate set and clear registers, in which a 1 in the write data acts on the matching pin and a 0 leaves that pin alone. Independent agents can therefore flip their own pins without a read-modify-write and without disturbing each other.

Raw pad levels pass through a two-flop synchronizer into a read-only input register. The latch and enable bits go straight to the pad ring on `pad_out_o` and `pad_oe_o`. A bus read is accepted in the cycle where `req_i` is high and `we_i` is low. Its data appears on `rdata_o`, with `rvalid_o` high, in the following cycle.

Top module: `gpio_w1_port`

## Requirements
- R1: A write to offset 0x00 sets the output latch bit of every pin whose write-data bit is 1. All other latch bits keep their value. The change shows on `pad_out_o` in the cycle after the write.
- R2: A write to offset 0x10 clears the output latch bit of every pin whose write-data bit is 1. All other latch bits keep their value.
- R3: A write to offset 0x20 sets the drive-enable bit (`pad_oe_o`) of every pin whose write-data bit is 1. All other enable bits keep their value.
- R4: A write to offset 0x30 clears the drive-enable bit, so the pin is tri-stated, for every pin whose write-data bit is 1. All other enable bits keep their value.
- R5: A read of offset 0x40 returns the synchronized pad levels, with bit n for pin n. The result appears on `rdata_o`, with `rvalid_o` high, exactly one cycle after the read is accepted.
- R6: A pad level that changes just before clock edge E is not seen by a read accepted at edge E or at edge E+1. It is first returned by a read accepted at edge E+2.
- R7: While `rst_ni` is low, all latch bits are 0, all drive enables are 0 (every pin is tri-stated), and `rvalid_o` and `rdata_o` are 0.
- R8: A read of offsets 0x00, 0x10, 0x20 or 0x30, or of any unmapped offset, returns 0.
- R9: A write to offset 0x40 or to any unmapped offset changes neither `pad_out_o` nor `pad_oe_o`.
- R10: The latch bits and the enable bits are independent. A latch write leaves `pad_oe_o` unchanged, an enable write leaves `pad_out_o` unchanged, and `pad_out_o` shows the latch whether or not the pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data, one bit per pin |
| rdata_o | output | 32 | Read data, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| pad_in_i | input | 32 | Raw asynchronous pad levels |
| pad_out_o | output | 32 | Output latch value per pin |
| pad_oe_o | output | 32 | Drive enable per pin, 1 = driven |

## Verification
The bench writes overlapping masks to each set and clear register and checks that bits outside a mask survive. A design that applied a write as a plain store would wipe the neighbouring pins. It writes to the input offset and to unmapped offsets, which a loose address decoder would alias onto a latch or enable register. It also reads the write-only offsets, which would leak latch state if the read path were not decoded. It steps a pad change through three back-to-back reads and expects old, old, new. A design with one synchronizer stage too few or too many would move the point where the new value first appears.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_OUT_SET = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OE_SET  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_OE_CLR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_IN      = 8'h40;

  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_OUT_SET = 3'd1,
    ACC_OUT_CLR = 3'd2,
    ACC_OE_SET  = 3'd3,
    ACC_OE_CLR  = 3'd4,
    ACC_IN      = 3'd5
  } acc_e;
endpackage

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
  import gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              acc_o
);
  always_comb begin
    unique case (addr_i)
      OFS_OUT_SET: acc_o = ACC_OUT_SET;
      OFS_OUT_CLR: acc_o = ACC_OUT_CLR;
      OFS_OE_SET:  acc_o = ACC_OE_SET;
      OFS_OE_CLR:  acc_o = ACC_OE_CLR;
      OFS_IN:      acc_o = ACC_IN;
      default:     acc_o = ACC_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_m, clr_m;

  assign set_m = set_i ? mask_i : '0;
  assign clr_m = clr_i ? mask_i : '0;

  // clear wins if both strobes ever coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_m) & ~clr_m;
  end

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ((q_o & $past(mask_i)) == $past(mask_i))); // R1, R3
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(mask_i)) == '0)); // R2, R4
  AST_UNMASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> (((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o)); // R9
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          warm_q <= '0;
      else if (warm_q != 2) warm_q <= warm_q + 2'd1;
    end
    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2) |-> (q_o == $past(d_i, 2))); // R6
  end
endmodule

// File: rtl/gpio_w1_port.sv
module gpio_w1_port
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                rvalid_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  acc_e                acc;
  logic                wr, rd;
  logic [NUM_PINS-1:0] pad_sync;

  gpio_bus_dec u_dec (.addr_i(addr_i), .acc_o(acc));

  assign wr = req_i &  we_i;
  assign rd = req_i & !we_i;

  gpio_setclr_reg #(.W(NUM_PINS)) u_out_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wr && acc == ACC_OUT_SET),
    .clr_i (wr && acc == ACC_OUT_CLR),
    .mask_i(wdata_i),
    .q_o   (pad_out_o)
  );

  gpio_setclr_reg #(.W(NUM_PINS)) u_oe_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wr && acc == ACC_OE_SET),
    .clr_i (wr && acc == ACC_OE_CLR),
    .mask_i(wdata_i),
    .q_o   (pad_oe_o)
  );

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= (acc == ACC_IN) ? pad_sync : '0;
    end
  end

  AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o); // R5
  AST_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && acc != ACC_IN) |=> (rdata_o == '0)); // R8
  AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (acc == ACC_IN || acc == ACC_NONE)) |=> ($stable(pad_out_o) && $stable(pad_oe_o))); // R9
  AST_OUT_KEEPS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (acc == ACC_OUT_SET || acc == ACC_OUT_CLR)) |=> $stable(pad_oe_o)); // R10
  AST_OE_KEEPS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (acc == ACC_OE_SET || acc == ACC_OE_CLR)) |=> $stable(pad_out_o)); // R10
endmodule

// File: tb/gpio_w1_port_test.sv
module gpio_w1_port_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic        rvalid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gpio_w1_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drivers are entered at a negedge and return at the next one
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: scoreboard pop on each returned read
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pad_out, 32'h0, "R7 latch in reset");
    chk(pad_oe, 32'h0, "R7 oe in reset");
    chk({31'h0, rvalid}, 32'h0, "R7 rvalid in reset");
    chk(rdata, 32'h0, "R7 rdata in reset");
    rst_ni = 1'b1;
    @(negedge clk);

    bus_write(8'h00, 32'hA5A5_0F0F);
    chk(pad_out, 32'hA5A5_0F0F, "R1 set");
    bus_write(8'h00, 32'h0000_00F0);
    chk(pad_out, 32'hA5A5_0FFF, "R1 set keeps others");
    bus_write(8'h10, 32'h0000_0F00);
    chk(pad_out, 32'hA5A5_00FF, "R2 clear");
    bus_write(8'h10, 32'h0);
    chk(pad_out, 32'hA5A5_00FF, "R2 zero mask");
    chk(pad_oe, 32'h0, "R10 oe untouched by latch writes");

    bus_write(8'h20, 32'hFFFF_0000);
    chk(pad_oe, 32'hFFFF_0000, "R3 oe set");
    chk(pad_out, 32'hA5A5_00FF, "R10 latch untouched by oe set");
    bus_write(8'h20, 32'h0000_0001);
    chk(pad_oe, 32'hFFFF_0001, "R3 oe set keeps others");
    bus_write(8'h30, 32'h0F0F_0001);
    chk(pad_oe, 32'hF0F0_0000, "R4 oe clear");
    chk(pad_out, 32'hA5A5_00FF, "R10 latch untouched by oe clear");

    bus_write(8'h10, 32'hFFFF_FFFF);
    chk(pad_out, 32'h0, "R2 clear all");
    chk(pad_oe, 32'hF0F0_0000, "R10 oe kept");
    bus_write(8'h00, 32'h0000_8000);
    chk(pad_out, 32'h0000_8000, "R10 latch on tri-stated pin");

    bus_write(8'h40, 32'hFFFF_FFFF);
    chk(pad_out, 32'h0000_8000, "R9 input write latch");
    chk(pad_oe, 32'hF0F0_0000, "R9 input write oe");
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_write(8'h31, 32'hFFFF_FFFF);
    chk(pad_out, 32'h0000_8000, "R9 unmapped write latch");
    chk(pad_oe, 32'hF0F0_0000, "R9 unmapped write oe");

    bus_write(8'h00, 32'h1234_5678);
    bus_read(8'h00, 32'h0, "R8 read out-set");
    bus_read(8'h10, 32'h0, "R8 read out-clr");
    bus_read(8'h20, 32'h0, "R8 read oe-set");
    bus_read(8'h30, 32'h0, "R8 read oe-clr");
    bus_read(8'h04, 32'h0, "R8 read unmapped");

    pad_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    bus_read(8'h40, 32'hDEAD_BEEF, "R5 input read");
    pad_in = 32'h0000_0001;
    repeat (3) @(negedge clk);
    bus_read(8'h40, 32'h0000_0001, "R5 bit0 is pin0");
    pad_in = 32'h8000_0000;
    repeat (3) @(negedge clk);
    bus_read(8'h40, 32'h8000_0000, "R5 bit31 is pin31");

    pad_in = 32'h5555_AAAA;
    bus_read(8'h40, 32'h8000_0000, "R6 edge E old");
    bus_read(8'h40, 32'h8000_0000, "R6 edge E+1 old");
    bus_read(8'h40, 32'h5555_AAAA, "R6 edge E+2 new");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 32'h0, "R5 all reads returned");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule